// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

This block decides, for each read that crosses a bus bridge, whether the bridge may fetch more data than the requester asked for. It looks at the 4-bit bus command, the side the read came from (primary or secondary), the address, and a small set of programmed settings: a prefetchable memory window (lower and upper 4 KB page bounds) and an enable for speculative treatment of plain memory reads that arrive from the secondary side.

A read that qualifies goes out on the destination side as an 8-doubleword burst. Every byte lane is enabled, and a plain memory read is upgraded to the line-read command. A read that does not qualify goes out unchanged as a single doubleword with the requester's own byte enables. Returned doublewords collect in an 8-entry FIFO that the requester drains. When the requester ends the transaction, whatever is still buffered is dropped in one cycle, and the block is ready for the next read.

Settings are written through a narrow write port. Select 0 holds the window's low page (address bits 31:12 taken from write data bits 31:12). Select 1 holds the window's high page, in the same layout. Select 2 holds the enable in bit 0. Out of reset the low page is 0xFFFFF, the high page is 0x00000 and the enable is 0, so nothing is prefetched.

Top module: `bridge_prefetch_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and dst_valid and rsp_valid are 0.
- R2: A Memory Read Multiple (4'b1100) or Memory Read Line (4'b1110) is prefetched from either side. The destination read keeps the command, has dst_len 8 and dst_be 4'hF.
- R3: A plain Memory Read (4'b0110) from the primary side (req_from_sec=0) is prefetched only when the page addr[31:12] satisfies low <= page <= high. It is then issued as 4'b1110 with dst_len 8 and dst_be 4'hF.
- R4: A plain Memory Read from the secondary side (req_from_sec=1) is prefetched exactly when the enable bit is 1, with the window ignored. Clearing the bit turns this off.
- R5: Every read that does not qualify, including all I/O Read (4'b0010), Configuration Read (4'b1010), write, dual-address and reserved codes, is issued with its own command, its own byte enables and dst_len 1. dst_addr always equals the accepted req_addr.
- R6: A read is accepted when req_valid and req_ready are both 1 at a clock edge. dst_valid is then 1 for exactly the following cycle. req_ready stays 0 until the transaction ends.
- R7: Returned doublewords reach rsp_data in arrival order. At most dst_len of them are stored, and any beyond that are ignored.
- R8: A req_done pulse during a transaction discards all buffered data: rsp_valid is 0 and req_ready is 1 in the next cycle.
- R9: With the reset settings, no plain Memory Read from either side is prefetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select: 0 low page, 1 high page, 2 enable |
| cfg_wdata | input | 32 | Setting write data |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request may be accepted |
| req_cmd | input | 4 | Bus command of the request |
| req_from_sec | input | 1 | 1 when the request came from the secondary side |
| req_addr | input | 32 | Request address |
| req_be | input | 4 | Request byte enables, active high |
| req_done | input | 1 | Requester ends the transaction |
| dst_valid | output | 1 | Destination read issue pulse |
| dst_cmd | output | 4 | Destination command |
| dst_addr | output | 32 | Destination address |
| dst_be | output | 4 | Destination byte enables, active high |
| dst_len | output | 4 | Doublewords requested |
| dst_rdata_valid | input | 1 | Returned doubleword present |
| dst_rdata | input | 32 | Returned doubleword |
| rsp_valid | output | 1 | Buffered data available |
| rsp_data | output | 32 | Oldest buffered doubleword |
| rsp_ready | input | 1 | Requester takes the oldest word |

## Verification
The destination read fields and the dst_valid pulse appear in the cycle right after the accepting edge. The bench therefore drives a request on a falling edge, lets one rising edge pass, and samples at the next falling edge. It then checks one edge later that the pulse has dropped. A returned doubleword is visible on rsp_data after the edge that stores it, and a pop or a flush takes effect at the following edge. Each check is made on the falling edge after that one register stage. The permission decision is swept over all 16 command codes, both sides, both enable values and four addresses that sit on and just past the window's ends.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam logic [3:0] CMD_IORD  = 4'b0010;
  localparam logic [3:0] CMD_MRD   = 4'b0110;
  localparam logic [3:0] CMD_CFGRD = 4'b1010;
  localparam logic [3:0] CMD_MRM   = 4'b1100;
  localparam logic [3:0] CMD_MRL   = 4'b1110;

  localparam int PAGE_W = 20;

  typedef enum logic {ST_IDLE, ST_ACTIVE} pf_state_e;

  // inclusive page window test
  function automatic logic page_in_window(input logic [PAGE_W-1:0] page,
                                          input logic [PAGE_W-1:0] lo,
                                          input logic [PAGE_W-1:0] hi);
    return (page >= lo) && (page <= hi);
  endfunction

  // permission rule: command, origin side, window hit, secondary enable
  function automatic logic prefetch_ok(input logic [3:0] cmd,
                                       input logic       from_sec,
                                       input logic       win_hit,
                                       input logic       sec_en);
    if (cmd == CMD_MRM || cmd == CMD_MRL) return 1'b1;
    if (cmd == CMD_MRD) return from_sec ? sec_en : win_hit;
    return 1'b0;
  endfunction

  function automatic logic [3:0] upgrade_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MRD) ? CMD_MRL : cmd;
  endfunction
endpackage

// File: rtl/pf_cfg.sv
module pf_cfg
  import pf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output logic [PAGE_W-1:0] win_lo,
  output logic [PAGE_W-1:0] win_hi,
  output logic              sec_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lo <= '1;
      win_hi <= '0;
      sec_en <= 1'b0;
    end else if (wr) begin
      case (sel)
        2'd0:    win_lo <= wdata[31:32-PAGE_W];
        2'd1:    win_hi <= wdata[31:32-PAGE_W];
        2'd2:    sec_en <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pf_decide.sv
module pf_decide
  import pf_pkg::*;
#(
  parameter bit WIN_PRESENT = 1'b1
) (
  input  logic [3:0]        cmd,
  input  logic              from_sec,
  input  logic [31:0]       addr,
  input  logic [3:0]        be,
  input  logic [PAGE_W-1:0] win_lo,
  input  logic [PAGE_W-1:0] win_hi,
  input  logic              sec_en,
  output logic              pf,
  output logic [3:0]        out_cmd,
  output logic [3:0]        out_be
);
  logic win_hit;

  generate
    if (WIN_PRESENT) begin : g_win
      assign win_hit = page_in_window(addr[31:32-PAGE_W], win_lo, win_hi);
    end else begin : g_nowin
      assign win_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    pf      = prefetch_ok(cmd, from_sec, win_hit, sec_en);
    out_cmd = pf ? upgrade_cmd(cmd) : cmd;
    out_be  = pf ? 4'hF : be;
  end
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              do_push, do_pop;

  assign do_push = push && (count < CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/bridge_prefetch_ctrl.sv
module bridge_prefetch_ctrl
  import pf_pkg::*;
#(
  parameter bit WIN_PRESENT = 1'b1,
  parameter int BURST_LEN   = 8,
  localparam int LW         = $clog2(BURST_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_cmd,
  input  logic          req_from_sec,
  input  logic [31:0]   req_addr,
  input  logic [3:0]    req_be,
  input  logic          req_done,
  output logic          dst_valid,
  output logic [3:0]    dst_cmd,
  output logic [31:0]   dst_addr,
  output logic [3:0]    dst_be,
  output logic [LW-1:0] dst_len,
  input  logic          dst_rdata_valid,
  input  logic [31:0]   dst_rdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  input  logic          rsp_ready
);
  logic [PAGE_W-1:0] win_lo, win_hi;
  logic              sec_en;
  logic              dec_pf;
  logic [3:0]        dec_cmd, dec_be;
  pf_state_e         st;
  logic [LW-1:0]     recv_cnt;

  // named events for the checker
  logic          accept_evt, fifo_push, fifo_flush, fifo_pop;
  logic [LW-1:0] fifo_cnt;

  pf_cfg u_cfg (
    .clk, .rst_n, .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .win_lo, .win_hi, .sec_en
  );

  pf_decide #(.WIN_PRESENT(WIN_PRESENT)) u_dec (
    .cmd(req_cmd), .from_sec(req_from_sec), .addr(req_addr), .be(req_be),
    .win_lo, .win_hi, .sec_en,
    .pf(dec_pf), .out_cmd(dec_cmd), .out_be(dec_be)
  );

  assign req_ready  = (st == ST_IDLE);
  assign accept_evt = req_valid && req_ready;
  assign fifo_flush = (st == ST_ACTIVE) && req_done;
  assign fifo_push  = (st == ST_ACTIVE) && !req_done && dst_rdata_valid
                      && (recv_cnt < dst_len);
  assign fifo_pop   = rsp_ready;
  assign rsp_valid  = (fifo_cnt != '0);

  pf_fifo #(.DEPTH(BURST_LEN), .DATA_W(32)) u_buf (
    .clk, .rst_n, .flush(fifo_flush), .push(fifo_push), .wdata(dst_rdata),
    .pop(fifo_pop), .rdata(rsp_data), .count(fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dst_valid <= 1'b0;
      dst_cmd   <= '0;
      dst_addr  <= '0;
      dst_be    <= '0;
      dst_len   <= '0;
      recv_cnt  <= '0;
    end else begin
      dst_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept_evt) begin
          st        <= ST_ACTIVE;
          dst_valid <= 1'b1;
          dst_cmd   <= dec_cmd;
          dst_addr  <= req_addr;
          dst_be    <= dec_be;
          dst_len   <= dec_pf ? LW'(BURST_LEN) : LW'(1);
          recv_cnt  <= '0;
        end
        ST_ACTIVE: begin
          if (req_done)       st       <= ST_IDLE;
          else if (fifo_push) recv_cnt <= recv_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import pf_pkg::*;
#(
  parameter int BURST_LEN = 8,
  localparam int LW       = $clog2(BURST_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          req_done,
  input logic          dst_valid,
  input logic [3:0]    dst_cmd,
  input logic [3:0]    dst_be,
  input logic [LW-1:0] dst_len,
  input logic          rsp_valid,
  input logic          fifo_push,
  input logic [LW-1:0] fifo_cnt
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> !dst_valid);

  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> !req_ready);

  a_r2_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_len == LW'(BURST_LEN)) |-> dst_be == 4'hF);

  a_r3_burst_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_len == LW'(BURST_LEN)) |-> (dst_cmd == CMD_MRM || dst_cmd == CMD_MRL));

  a_r5_io_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && (dst_cmd == CMD_IORD || dst_cmd == CMD_CFGRD)) |-> dst_len == LW'(1));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> fifo_cnt < LW'(BURST_LEN));

  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !req_ready) |=> (!rsp_valid && req_ready));
endmodule

bind bridge_prefetch_ctrl pf_checker #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
  .dst_valid(dst_valid), .dst_cmd(dst_cmd), .dst_be(dst_be), .dst_len(dst_len),
  .rsp_valid(rsp_valid), .fifo_push(fifo_push), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_bridge_prefetch_ctrl.sv
module tb_bridge_prefetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic        req_from_sec = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_done = 1'b0;
  logic        dst_valid;
  logic [3:0]  dst_cmd;
  logic [31:0] dst_addr;
  logic [3:0]  dst_be;
  logic [3:0]  dst_len;
  logic        dst_rdata_valid = 1'b0;
  logic [31:0] dst_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bridge_prefetch_ctrl dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // issue one read and check the destination fields; leaves transaction open
  task automatic issue(input logic [3:0] cmd, input bit sec, input logic [31:0] a,
                       input logic [3:0] be, input bit exp_pf, input string req);
    logic [3:0] ecmd, ebe, elen;
    ecmd = (exp_pf && cmd == 4'b0110) ? 4'b1110 : cmd;
    ebe  = exp_pf ? 4'hF : be;
    elen = exp_pf ? 4'd8 : 4'd1;
    req_valid = 1'b1; req_cmd = cmd; req_from_sec = sec; req_addr = a; req_be = be;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(dst_valid == 1'b1, "R6 pulse", 64'(dst_valid), 64'd1);
    check(req_ready == 1'b0, "R6 busy", 64'(req_ready), 64'd0);
    check(dst_cmd == ecmd, req, 64'(dst_cmd), 64'(ecmd));
    check(dst_be == ebe, req, 64'(dst_be), 64'(ebe));
    check(dst_len == elen, req, 64'(dst_len), 64'(elen));
    check(dst_addr == a, "R5 addr", 64'(dst_addr), 64'(a));
    @(posedge clk); @(negedge clk);
    check(dst_valid == 1'b0, "R6 pulse end", 64'(dst_valid), 64'd0);
  endtask

  task automatic finish_txn();
    req_done = 1'b1;
    @(posedge clk); @(negedge clk);
    req_done = 1'b0;
    check(rsp_valid == 1'b0, "R8 flush", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R8 ready", 64'(req_ready), 64'd1);
  endtask

  task automatic feed(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      dst_rdata_valid = 1'b1; dst_rdata = base + 32'(i);
      @(posedge clk); @(negedge clk);
    end
    dst_rdata_valid = 1'b0;
  endtask

  task automatic take(input logic [31:0] exp);
    check(rsp_valid == 1'b1, "R7 valid", 64'(rsp_valid), 64'd1);
    check(rsp_data == exp, "R7 order", 64'(rsp_data), 64'(exp));
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic bit model_pf(input logic [3:0] cmd, input bit sec,
                                  input logic [31:0] a, input bit en);
    bit inwin;
    inwin = (a >= 32'h0001_0000) && (a <= 32'h0001_FFFF);
    if (cmd == 4'b1100 || cmd == 4'b1110) return 1'b1;
    if (cmd == 4'b0110) return sec ? en : inwin;
    return 1'b0;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [4];
    addrs[0] = 32'h0001_0000; addrs[1] = 32'h0001_FFFC;
    addrs[2] = 32'h0000_FFFC; addrs[3] = 32'h0002_0000;

    @(negedge clk); @(negedge clk);
    // R1 values in reset and after release
    check(req_ready == 1'b1 && dst_valid == 1'b0 && rsp_valid == 1'b0, "R1 reset",
          {61'd0, req_ready, dst_valid, rsp_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && dst_valid == 1'b0 && rsp_valid == 1'b0, "R1 idle",
          {61'd0, req_ready, dst_valid, rsp_valid}, 64'd4);

    // R9 reset settings: plain memory reads never prefetched
    issue(4'b0110, 1'b0, 32'h0000_0000, 4'h3, 1'b0, "R9 primary lo"); finish_txn();
    issue(4'b0110, 1'b0, 32'hFFFF_F000, 4'h3, 1'b0, "R9 primary hi"); finish_txn();
    issue(4'b0110, 1'b1, 32'h0001_0000, 4'h3, 1'b0, "R9 secondary"); finish_txn();

    // program window pages 0x00010..0x0001F
    cfg_write(2'd0, 32'h0001_0000);
    cfg_write(2'd1, 32'h0001_F000);

    // sweep: every code, both sides, both enable values, window edges
    for (int en = 0; en < 2; en++) begin
      cfg_write(2'd2, 32'(en));
      for (int c = 0; c < 16; c++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 4; k++) begin
            bit p;
            string tag;
            p = model_pf(4'(c), s[0], addrs[k], en[0]);
            if (c == 12 || c == 14)      tag = "R2 line/multiple";
            else if (c == 6 && s == 0)   tag = "R3 window";
            else if (c == 6)             tag = "R4 secondary enable";
            else                         tag = "R5 never";
            issue(4'(c), s[0], addrs[k], 4'(c ^ 5), p, tag);
            finish_txn();
          end
    end

    // R7 ordered delivery, extras beyond burst ignored
    issue(4'b1100, 1'b0, 32'h0000_4000, 4'h1, 1'b1, "R2 data");
    feed(10, 32'hA000_0000);
    for (int i = 0; i < 8; i++) take(32'hA000_0000 + 32'(i));
    check(rsp_valid == 1'b0, "R7 extras ignored", 64'(rsp_valid), 64'd0);
    finish_txn();

    // R7 single read keeps only one word
    issue(4'b0010, 1'b1, 32'h0000_0010, 4'h2, 1'b0, "R5 io");
    feed(3, 32'hB000_0000);
    take(32'hB000_0000);
    check(rsp_valid == 1'b0, "R7 single", 64'(rsp_valid), 64'd0);
    finish_txn();

    // R8 partial consumption then flush; nothing survives into next read
    issue(4'b1110, 1'b1, 32'h0000_8000, 4'h0, 1'b1, "R2 flush");
    feed(5, 32'hC000_0000);
    take(32'hC000_0000);
    take(32'hC000_0001);
    finish_txn();
    issue(4'b1100, 1'b0, 32'h0000_9000, 4'h0, 1'b1, "R8 next");
    check(rsp_valid == 1'b0, "R8 discarded", 64'(rsp_valid), 64'd0);
    feed(1, 32'hD000_0000);
    take(32'hD000_0000);
    finish_txn();

    // R4 enable cleared turns secondary treatment off
    cfg_write(2'd2, 32'd0);
    issue(4'b0110, 1'b1, 32'h0001_0000, 4'h7, 1'b0, "R4 disabled"); finish_txn();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule